// File: doc/BRIEF.md
# Flash Refresh Scheduler

This block decides when each flash block needs its stored data rewritten to stay ahead of retention loss, and walks the pages of that block through a read, correct and write-back sequence. Each block carries a wear figure (its program/erase count) supplied from outside. A set of ascending wear breakpoints picks one of several refresh intervals for the block. A lightly worn block needs no refresh at all. Heavier wear selects shorter intervals, ranging from the order of years down to days. A shared tick advances a per-block elapsed-time counter. A block becomes due when its elapsed time reaches the interval of its wear tier.

For a due block, the scheduler issues one page read at a time, in ascending page order. The read data goes through an external error-correction stage, which returns two things: an uncorrectable flag, and a count of corrected bits that had shifted in the direction typical of program disturb. A count under a programmable threshold rewrites the page in place. A count at or above the threshold asks the mapping layer for a fresh page; the old block is left for later garbage collection. An uncorrectable page is skipped without any write, and an error pulse is raised. When the last page finishes, the block's elapsed counter starts again from zero.

Read requests, correction results and write requests are valid/ready streams. A request is held with its payload unchanged until the receiver accepts it. The scheduler takes a correction result only when it is waiting for one. Nothing about the sequence advances while a receiver holds off, so back-pressure may last as long as needed.

Top module: `flash_refresh_sched`

## Requirements
- R1: After reset no read request, write request, correction acceptance or error pulse is active, and every block's elapsed count is zero.
- R2: A block whose wear count is below the lowest breakpoint is never refreshed. Otherwise its tier is the highest index k with wear >= breakpoint k, where breakpoints are checked in ascending order and tier k uses interval entry k.
- R3: A block becomes due once its elapsed tick count is at least its tier's interval, and the first read request follows. This includes a block whose wear crosses into a tier after its elapsed count has already passed that tier's interval.
- R4: The pages of a due block are handled one at a time, from page 0 to the last page. The address is {block, page}, with the page number in the low PAGE_W bits.
- R5: A read request is held, with its address unchanged, until rd_ready is seen high.
- R6: For a correctable page, a rshift count below cfg_rshift_thr gives a write with wr_remap = 0 (in place). A count equal to or above the threshold gives wr_remap = 1 (move to a fresh page).
- R7: An uncorrectable result gives no write for that page and a one-cycle uncorr_flag pulse in the cycle after acceptance, and the sequence moves on to the next page.
- R8: A write request is held, with address and remap bit unchanged, until wr_ready is seen high.
- R9: After the last page of a block, that block's elapsed count restarts from zero, so its next refresh begins a full interval later.
- R10: When several blocks are due, the lowest-numbered block is refreshed first, and its pages all finish before another block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse; advances every block's elapsed count |
| blk_pe | input | NUM_BLOCKS*PE_W | Program/erase count per block, block i in bits [i*PE_W +: PE_W] |
| cfg_pe_bp | input | NUM_TIERS*PE_W | Ascending wear breakpoints, tier k in [k*PE_W +: PE_W] |
| cfg_intv | input | NUM_TIERS*TIME_W | Refresh interval in ticks per tier, tier k in [k*TIME_W +: TIME_W] |
| cfg_rshift_thr | input | CNT_W | Right-shift error count at which a page is remapped |
| rd_valid | output | 1 | Page read request valid |
| rd_ready | input | 1 | Page read request accepted |
| rd_addr | output | BLK_W+PAGE_W | Page to read, {block, page} |
| ecc_valid | input | 1 | Correction result valid |
| ecc_ready | output | 1 | Scheduler is waiting for a correction result |
| ecc_uncorr | input | 1 | Page could not be corrected |
| ecc_rshift | input | CNT_W | Count of corrected right-shift bit errors |
| wr_valid | output | 1 | Write-back request valid |
| wr_ready | input | 1 | Write-back request accepted |
| wr_addr | output | BLK_W+PAGE_W | Page whose corrected data is written back |
| wr_remap | output | 1 | 1: write to a newly mapped page; 0: reprogram in place |
| uncorr_flag | output | 1 | One-cycle pulse on an uncorrectable page |

## Verification
Assertions check the handshake rules on every cycle. A pending read or write keeps its payload until it is accepted, and a correction result is taken only while the scheduler waits for one. They also check that a new block always begins at page 0, that an error pulse never comes with a write, that the remap bit follows the threshold comparison of the result just taken, and that a block only starts when it is the lowest-numbered due block. Only the bench's scenarios can show the timing properties. These are the tick count at which each wear tier first triggers a read, the complete absence of refresh for young blocks, the restart of the interval after the last page, and the block order across several due blocks. The bench measures each of these against intervals and tiers it computes from its own configuration.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_ECC   = 2'd2,
    ST_WRITE = 2'd3
  } frs_state_e;
endpackage

// File: rtl/frs_tier_sel.sv
module frs_tier_sel #(
  parameter int PE_W      = 16,
  parameter int NUM_TIERS = 4,
  parameter int TIER_W    = (NUM_TIERS > 1) ? $clog2(NUM_TIERS) : 1
) (
  input  logic [PE_W-1:0]           pe,
  input  logic [NUM_TIERS*PE_W-1:0] bp,
  output logic                      en,
  output logic [TIER_W-1:0]         tier
);
  // breakpoints walked from lowest to highest; the last one passed wins
  always_comb begin
    en   = 1'b0;
    tier = '0;
    for (int k = 0; k < NUM_TIERS; k++) begin
      if (pe >= bp[k*PE_W +: PE_W]) begin
        en   = 1'b1;
        tier = TIER_W'(k);
      end
    end
  end
endmodule

// File: rtl/frs_age_ctr.sv
module frs_age_ctr #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  output logic [TIME_W-1:0] count
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      count <= '0;
    else if (tick && count != CNT_MAX)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/frs_due_arb.sv
module frs_due_arb #(
  parameter int NUM_BLOCKS = 4,
  parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic [NUM_BLOCKS-1:0] due,
  output logic                  any,
  output logic [BLK_W-1:0]      idx
);
  always_comb begin
    any = |due;
    idx = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
      if (due[i]) idx = BLK_W'(i);
    end
  end
endmodule

// File: rtl/frs_seq.sv
module frs_seq
  import frs_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int BLK_W     = 2,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = BLK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  start_blk,
  input  logic [CNT_W-1:0]  thr,
  output logic              busy,
  output logic              blk_done,
  output logic [BLK_W-1:0]  cur_blk,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              ecc_valid,
  output logic              ecc_ready,
  input  logic              ecc_uncorr,
  input  logic [CNT_W-1:0]  ecc_rshift,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_remap,
  output logic              uncorr_flag
);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  frs_state_e        state;
  logic [PAGE_W-1:0] page;
  logic              remap_q;
  logic              flag_q;
  logic              ecc_take, wr_take, advance;

  always_comb begin
    ecc_take  = (state == ST_ECC) && ecc_valid;
    wr_take   = (state == ST_WRITE) && wr_ready;
    advance   = (ecc_take && ecc_uncorr) || wr_take;
    blk_done  = advance && (page == LAST_PAGE);
    busy      = (state != ST_IDLE);
    rd_valid  = (state == ST_READ);
    ecc_ready = (state == ST_ECC);
    wr_valid  = (state == ST_WRITE);
    rd_addr   = {cur_blk, page};
    wr_addr   = {cur_blk, page};
    wr_remap  = remap_q;
    uncorr_flag = flag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_blk <= '0;
      page    <= '0;
      remap_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= ecc_take && ecc_uncorr;
      case (state)
        ST_IDLE: if (start) begin
          cur_blk <= start_blk;
          page    <= '0;
          state   <= ST_READ;
        end
        ST_READ: if (rd_ready) state <= ST_ECC;
        ST_ECC: if (ecc_valid && !ecc_uncorr) begin
          remap_q <= (ecc_rshift >= thr);
          state   <= ST_WRITE;
        end
        default: ;
      endcase
      if (advance) begin
        if (page == LAST_PAGE) begin
          state <= ST_IDLE;
        end else begin
          page  <= page + 1'b1;
          state <= ST_READ;
        end
      end
    end
  end

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_remap));

  assert_first_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) && !$past(busy) |-> rd_addr[PAGE_W-1:0] == '0);

  assert_abort_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_flag |-> !wr_valid);

  assert_remap_choice_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_remap == ($past(ecc_rshift) >= $past(thr)));
endmodule

// File: rtl/flash_refresh_sched.sv
module flash_refresh_sched #(
  parameter int NUM_BLOCKS = 4,
  parameter int NUM_PAGES  = 4,
  parameter int NUM_TIERS  = 4,
  parameter int PE_W       = 16,
  parameter int TIME_W     = 16,
  parameter int CNT_W      = 8,
  parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  parameter int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [NUM_BLOCKS*PE_W-1:0]  blk_pe,
  input  logic [NUM_TIERS*PE_W-1:0]   cfg_pe_bp,
  input  logic [NUM_TIERS*TIME_W-1:0] cfg_intv,
  input  logic [CNT_W-1:0]            cfg_rshift_thr,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic [BLK_W+PAGE_W-1:0]     rd_addr,
  input  logic                        ecc_valid,
  output logic                        ecc_ready,
  input  logic                        ecc_uncorr,
  input  logic [CNT_W-1:0]            ecc_rshift,
  output logic                        wr_valid,
  input  logic                        wr_ready,
  output logic [BLK_W+PAGE_W-1:0]     wr_addr,
  output logic                        wr_remap,
  output logic                        uncorr_flag
);
  localparam int TIER_W = (NUM_TIERS > 1) ? $clog2(NUM_TIERS) : 1;

  logic [NUM_BLOCKS-1:0] due;
  logic                  any_due;
  logic [BLK_W-1:0]      pick;
  logic                  busy, blk_done, start;
  logic [BLK_W-1:0]      cur_blk;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    logic              tier_en;
    logic [TIER_W-1:0] tier;
    logic [TIME_W-1:0] age;
    logic [TIME_W-1:0] limit;

    frs_tier_sel #(.PE_W(PE_W), .NUM_TIERS(NUM_TIERS), .TIER_W(TIER_W)) u_tier (
      .pe   (blk_pe[i*PE_W +: PE_W]),
      .bp   (cfg_pe_bp),
      .en   (tier_en),
      .tier (tier)
    );

    frs_age_ctr #(.TIME_W(TIME_W)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (blk_done && (cur_blk == BLK_W'(i))),
      .count (age)
    );

    always_comb begin
      limit  = cfg_intv[tier*TIME_W +: TIME_W];
      due[i] = tier_en && (age >= limit);
    end
  end

  frs_due_arb #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_arb (
    .due (due),
    .any (any_due),
    .idx (pick)
  );

  assign start = any_due && !busy;

  frs_seq #(
    .NUM_PAGES(NUM_PAGES), .BLK_W(BLK_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_blk  (pick),
    .thr        (cfg_rshift_thr),
    .busy       (busy),
    .blk_done   (blk_done),
    .cur_blk    (cur_blk),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .ecc_valid  (ecc_valid),
    .ecc_ready  (ecc_ready),
    .ecc_uncorr (ecc_uncorr),
    .ecc_rshift (ecc_rshift),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_remap   (wr_remap),
    .uncorr_flag(uncorr_flag)
  );

  assert_start_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> due[pick] &&
      ((due & ((NUM_BLOCKS'(1) << pick) - NUM_BLOCKS'(1))) == '0));

  assert_busy_block_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rd_valid && (rd_addr[BLK_W+PAGE_W-1:PAGE_W] == $past(pick)));
endmodule

// File: tb/flash_refresh_sched_bench.sv
module flash_refresh_sched_bench;
  localparam int NB = 4, NP = 4, NT = 4, PW = 16, TW = 16, CW = 8;
  localparam int THR = 3;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [NB*PW-1:0] blk_pe = '0;
  logic [NT*PW-1:0] cfg_pe_bp;
  logic [NT*TW-1:0] cfg_intv;
  logic [CW-1:0]    cfg_rshift_thr = CW'(THR);
  logic rd_valid, rd_ready = 0, ecc_valid = 0, ecc_ready, ecc_uncorr = 0;
  logic [CW-1:0] ecc_rshift = '0;
  logic wr_valid, wr_ready = 0, wr_remap, uncorr_flag;
  logic [3:0] rd_addr, wr_addr;

  int errors = 0, checks = 0, cyc = 0;
  int bp [NT] = '{10, 20, 30, 40};
  int iv [NT] = '{16, 8, 4, 2};

  always #10 clk = ~clk;

  flash_refresh_sched u_flash_refresh_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .blk_pe(blk_pe), .cfg_pe_bp(cfg_pe_bp),
    .cfg_intv(cfg_intv), .cfg_rshift_thr(cfg_rshift_thr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .ecc_valid(ecc_valid), .ecc_ready(ecc_ready),
    .ecc_uncorr(ecc_uncorr), .ecc_rshift(ecc_rshift), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_remap(wr_remap), .uncorr_flag(uncorr_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tier_of(input int pe);
    int t = -1;
    for (int k = 0; k < NT; k++) if (pe >= bp[k]) t = k;
    return t;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; rd_ready = 0; ecc_valid = 0; wr_ready = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  // ticks given until a read request appears; 0 if none within maxn
  task automatic ticks_to_read(input int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn && n == 0; i++) begin
      tick_once();
      repeat (3) @(negedge clk);
      if (rd_valid) n = i;
    end
  endtask

  task automatic serve_page(input int blk, input int pg, input int rs, input bit fail,
                            input bit hold);
    int w = 0;
    while (!rd_valid && w < 20) begin @(negedge clk); w++; end
    chk(rd_valid, "R4 read request present", rd_valid, 1);
    chk(rd_addr == 4'(blk*NP + pg), "R4 page address order", rd_addr, blk*NP + pg);
    if (hold) begin
      logic [3:0] a0 = rd_addr;
      repeat (2) @(negedge clk);
      chk(rd_valid && rd_addr == a0, "R5 read held under back-pressure", rd_addr, a0);
    end
    rd_ready = 1;
    @(negedge clk); rd_ready = 0;
    ecc_valid = 1; ecc_uncorr = fail; ecc_rshift = CW'(rs);
    w = 0;
    while (!ecc_ready && w < 20) begin @(negedge clk); w++; end
    @(negedge clk); ecc_valid = 0; ecc_uncorr = 0;
    chk(uncorr_flag == fail, "R7 error pulse", uncorr_flag, fail);
    if (fail) begin
      chk(!wr_valid, "R7 no write after uncorrectable", wr_valid, 0);
      @(negedge clk);
      chk(!uncorr_flag, "R7 pulse lasts one cycle", uncorr_flag, 0);
      chk(!wr_valid, "R7 no write after uncorrectable", wr_valid, 0);
    end else begin
      w = 0;
      while (!wr_valid && w < 20) begin @(negedge clk); w++; end
      chk(wr_addr == 4'(blk*NP + pg), "R6 write address", wr_addr, blk*NP + pg);
      chk(wr_remap == (rs >= THR), "R6 remap decision", wr_remap, rs >= THR);
      if (hold) begin
        logic [3:0] a1 = wr_addr;
        logic r1 = wr_remap;
        repeat (2) @(negedge clk);
        chk(wr_valid && wr_addr == a1 && wr_remap == r1, "R8 write held", wr_addr, a1);
      end
      wr_ready = 1;
      @(negedge clk); wr_ready = 0;
    end
  endtask

  task automatic serve_block(input int blk, input int salt, input bit hold);
    for (int p = 0; p < NP; p++)
      serve_page(blk, p, (blk + salt + p) % 5, ((blk + salt + p) % 7) == 6, hold);
  endtask

  initial begin
    int n;
    for (int k = 0; k < NT; k++) begin
      cfg_pe_bp[k*PW +: PW] = PW'(bp[k]);
      cfg_intv[k*TW +: TW]  = TW'(iv[k]);
    end
    do_reset();
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !ecc_ready && !uncorr_flag, "R1 idle after reset",
        {rd_valid, wr_valid, ecc_ready, uncorr_flag}, 0);

    // young blocks: below the lowest breakpoint nothing happens
    for (int b = 0; b < NB; b++) begin
      do_reset();
      blk_pe = '0; blk_pe[b*PW +: PW] = PW'(bp[0] - 1);
      ticks_to_read(40, n);
      chk(n == 0, "R2 young block not refreshed", n, 0);
    end

    // sweep: every block at both edges of every tier
    for (int b = 0; b < NB; b++) begin
      for (int t = 0; t < NT; t++) begin
        for (int e = 0; e < 2; e++) begin
          int pe = (e == 0) ? bp[t] : ((t < NT - 1) ? bp[t+1] - 1 : bp[t] + 100);
          int et = tier_of(pe);
          do_reset();
          blk_pe = '0; blk_pe[b*PW +: PW] = PW'(pe);
          ticks_to_read(40, n);
          chk(n == iv[et], "R3 ticks until due (R2 tier choice)", n, iv[et]);
          serve_block(b, t * 2 + e, (t + e) % 2 == 1);
          @(negedge clk);
          chk(!rd_valid, "R4 block complete", rd_valid, 0);
          if (e == 1) begin
            ticks_to_read(40, n);
            chk(n == iv[et], "R9 interval restarts after last page", n, iv[et]);
            serve_block(b, 0, 1'b0);
          end
        end
      end
    end

    // wear crosses into a tier after elapsed time already exceeds it
    do_reset();
    blk_pe = '0;
    ticks_to_read(20, n);
    chk(n == 0, "R2 no refresh while young", n, 0);
    blk_pe[0 +: PW] = PW'(45);
    repeat (3) @(negedge clk);
    chk(rd_valid && rd_addr == 4'd0, "R3 due at once after tier change", rd_valid, 1);
    serve_block(0, 1, 1'b0);

    // two blocks due together: lower index first, whole block first
    do_reset();
    blk_pe = '0;
    blk_pe[2*PW +: PW] = PW'(25);
    blk_pe[1*PW +: PW] = PW'(25);
    ticks_to_read(40, n);
    chk(n == iv[1], "R3 shared due time", n, iv[1]);
    chk(rd_addr == 4'(1*NP), "R10 lowest block first", rd_addr, NP);
    serve_block(1, 3, 1'b0);
    serve_block(2, 3, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule